// File: doc/BRIEF.md
# Effective memory privilege selector

This block decides which privilege level governs a memory access. It takes the hart's current privilege, a flag that marks the access as an instruction fetch, the machine status register, the address-translation register and a privilege-spec version code. It produces the privilege level that later protection logic should check and a flag that shows whether translation is off (bare). When translation is off, the access is always treated as machine level.

Data accesses can borrow the previous-machine-privilege field of the status register when its modify-privilege bit is set. Instruction fetches never borrow it. The version input selects where the translation mode is read from. The older generation reads a 5-bit mode field in the status register. The newer generation reads the mode field of the address-translation register, whose position depends on the register width. Both outputs are registered and appear one clock after the inputs are sampled.

Top module: `mem_priv_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, eff_priv reads 3 (machine) and bare_mode reads 1.
- R2: The outputs reflect the inputs present at the previous rising clock edge. A change at the inputs does not reach the outputs before the next edge.
- R3: Privilege codes are user=0, supervisor=1, hypervisor=2 and machine=3. Whenever bare_mode is 1, eff_priv is 3.
- R4: When is_fetch is 1 and translation is on, eff_priv equals cur_priv, whatever status bit 17 holds.
- R5: When is_fetch is 0, status bit 17 is 1 and translation is on, eff_priv equals status bits 12:11.
- R6: When is_fetch is 0, status bit 17 is 0 and translation is on, eff_priv equals cur_priv.
- R7: In the newer mode, translation is off exactly when the translation-register mode field is 0. That field is bit 31 when XLEN=32 and bits 63:60 when XLEN=64.
- R8: In the older mode, translation is off exactly when status bits 28:24 are 0.
- R9: The newer mode is used when spec_version is 0x00011000 or above. Any lower code, such as 0x00010901 or 0x00010FFF, selects the older mode.
- R10: In the older mode, the translation register has no effect on the outputs. In the newer mode, status bits 28:24 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_priv | input | 2 | Current hart privilege |
| is_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| status | input | XLEN | Machine status register |
| xlat_reg | input | XLEN | Address-translation register |
| spec_version | input | 32 | Privilege-spec version code |
| eff_priv | output | 2 | Registered effective privilege |
| bare_mode | output | 1 | Registered translation-off flag |

## Verification
The hardest cases to reach are those where two selection rules meet. One is a data access with the override bit set while translation is off, where the borrowed privilege must be masked to machine level. The other is a version code that sits exactly at the generation boundary. The stimulus builds each of these cases on purpose. It loads contradictory values into the field that the selected generation must ignore. Examples are a nonzero status mode field with a zero translation mode in the newer generation, and the reverse case in the older generation. Each case is checked just below and at the version threshold.

// File: rtl/mem_priv_sel.sv
module mem_priv_sel #(
  parameter int XLEN = 32,
  parameter logic [31:0] NEW_SPEC_CODE = 32'h0001_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cur_priv,
  input  logic            is_fetch,
  input  logic [XLEN-1:0] status,
  input  logic [XLEN-1:0] xlat_reg,
  input  logic [31:0]     spec_version,
  output logic [1:0]      eff_priv,
  output logic            bare_mode
);
  localparam logic [1:0] PRIV_MACHINE = 2'd3;
  localparam int OVR_BIT  = 17;
  localparam int PREV_LO  = 11;
  localparam int OLD_VM_LO = 24;
  localparam int OLD_VM_W  = 5;

  logic       use_new;
  logic       new_bare;
  logic       old_bare;
  logic       borrow;
  logic [1:0] base_priv;
  logic       next_bare;

  generate
    if (XLEN == 64) begin : g_mode64
      assign new_bare = (xlat_reg[XLEN-1 -: 4] == 4'd0);
    end else begin : g_mode32
      assign new_bare = (xlat_reg[XLEN-1] == 1'b0);
    end
  endgenerate

  assign use_new   = (spec_version >= NEW_SPEC_CODE);
  assign old_bare  = (status[OLD_VM_LO +: OLD_VM_W] == '0);
  assign borrow    = !is_fetch && status[OVR_BIT];
  assign base_priv = borrow ? status[PREV_LO +: 2] : cur_priv;
  assign next_bare = use_new ? new_bare : old_bare;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_priv  <= PRIV_MACHINE;
      bare_mode <= 1'b1;
    end else begin
      eff_priv  <= next_bare ? PRIV_MACHINE : base_priv;
      bare_mode <= next_bare;
    end
  end

  a_r1_reset_machine: assert property (@(posedge clk)
    $rose(rst_n) |-> (eff_priv == PRIV_MACHINE && bare_mode));

  a_r3_bare_is_machine: assert property (@(posedge clk) disable iff (!rst_n)
    bare_mode |-> eff_priv == PRIV_MACHINE);

  a_r4_fetch_current: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> (bare_mode || eff_priv == $past(cur_priv)));

  a_r5_data_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fetch && status[OVR_BIT]) |=> (bare_mode || eff_priv == $past(status[PREV_LO +: 2])));

  a_r6_data_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !status[OVR_BIT] |=> (bare_mode || eff_priv == $past(cur_priv)));

  a_r8_old_bare: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_version < NEW_SPEC_CODE) |=> (bare_mode == ($past(status[OLD_VM_LO +: OLD_VM_W]) == 5'd0)));

endmodule

// File: tb/mem_priv_sel_tb.sv
module mem_priv_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cur_priv = 2'd0;
  logic        is_fetch = 1'b0;
  logic [31:0] status = '0;
  logic [31:0] xlat_reg = '0;
  logic [31:0] spec_version = 32'h0001_1000;
  logic [1:0]  eff_priv;
  logic        bare_mode;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] V_NEW = 32'h0001_1000;
  localparam logic [31:0] V_OLD = 32'h0001_0901;

  always #4 clk = ~clk;

  mem_priv_sel #(.XLEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .is_fetch(is_fetch),
    .status(status), .xlat_reg(xlat_reg), .spec_version(spec_version),
    .eff_priv(eff_priv), .bare_mode(bare_mode));

  function automatic logic [31:0] mk_st(logic ovr, logic [1:0] prev, logic [4:0] vm);
    return {3'b000, vm, 6'b0, ovr, 4'b0, prev, 11'h2A5};
  endfunction

  function automatic logic [31:0] mk_xl(logic mode);
    return {mode, 31'h0123_4567};
  endfunction

  task automatic chk(string req, logic [1:0] ep, logic eb);
    checks++;
    if (eff_priv !== ep || bare_mode !== eb) begin
      errors++;
      $display("FAIL %s: eff_priv=%0d bare=%0b expected eff_priv=%0d bare=%0b",
               req, eff_priv, bare_mode, ep, eb);
    end
  endtask

  task automatic apply(logic [1:0] cp, logic f, logic [31:0] st, logic [31:0] xl, logic [31:0] v);
    @(negedge clk);
    cur_priv = cp; is_fetch = f; status = st; xlat_reg = xl; spec_version = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cur_priv = 2'd0; status = mk_st(0, 0, 5'd9); xlat_reg = mk_xl(1);
    repeat (3) @(posedge clk);
    #1 chk("R1 during reset", 2'd3, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 before first edge", 2'd3, 1'b1);
  endtask

  task automatic t_latency;
    apply(2'd1, 1'b0, mk_st(0, 2'd0, 5'd0), mk_xl(1), V_NEW);
    chk("R2 settle", 2'd1, 1'b0);
    @(negedge clk); cur_priv = 2'd0;
    #1 chk("R2 no early change", 2'd1, 1'b0);
    @(posedge clk); #1 chk("R2 one edge later", 2'd0, 1'b0);
  endtask

  task automatic t_fetch;
    apply(2'd0, 1'b1, mk_st(1, 2'd2, 5'd0), mk_xl(1), V_NEW);
    chk("R4 fetch ignores override", 2'd0, 1'b0);
    apply(2'd2, 1'b1, mk_st(0, 2'd1, 5'd0), mk_xl(1), V_NEW);
    chk("R4 fetch current hyp", 2'd2, 1'b0);
  endtask

  task automatic t_data;
    apply(2'd3, 1'b0, mk_st(1, 2'd0, 5'd0), mk_xl(1), V_NEW);
    chk("R5 borrow user", 2'd0, 1'b0);
    apply(2'd0, 1'b0, mk_st(1, 2'd1, 5'd0), mk_xl(1), V_NEW);
    chk("R5 borrow super", 2'd1, 1'b0);
    apply(2'd1, 1'b0, mk_st(0, 2'd0, 5'd0), mk_xl(1), V_NEW);
    chk("R6 no borrow", 2'd1, 1'b0);
  endtask

  task automatic t_new_bare;
    apply(2'd0, 1'b0, mk_st(1, 2'd1, 5'd9), mk_xl(0), V_NEW);
    chk("R7 R3 new bare masks borrow", 2'd3, 1'b1);
    apply(2'd0, 1'b1, mk_st(0, 2'd0, 5'd9), mk_xl(0), 32'h0002_0000);
    chk("R7 new bare fetch", 2'd3, 1'b1);
    apply(2'd0, 1'b1, mk_st(0, 2'd0, 5'd0), mk_xl(1), V_NEW);
    chk("R10 new ignores status vm", 2'd0, 1'b0);
  endtask

  task automatic t_old;
    apply(2'd1, 1'b0, mk_st(0, 2'd0, 5'd0), mk_xl(1), V_OLD);
    chk("R8 old bare", 2'd3, 1'b1);
    apply(2'd1, 1'b0, mk_st(0, 2'd0, 5'd8), mk_xl(0), V_OLD);
    chk("R10 old ignores xlat", 2'd1, 1'b0);
    apply(2'd3, 1'b0, mk_st(1, 2'd0, 5'd16), mk_xl(1), V_OLD);
    chk("R8 old translated borrow", 2'd0, 1'b0);
  endtask

  task automatic t_boundary;
    apply(2'd1, 1'b1, mk_st(0, 2'd0, 5'd0), mk_xl(1), 32'h0001_0FFF);
    chk("R9 just below threshold is old", 2'd3, 1'b1);
    apply(2'd1, 1'b1, mk_st(0, 2'd0, 5'd0), mk_xl(1), 32'h0001_1000);
    chk("R9 at threshold is new", 2'd1, 1'b0);
    apply(2'd2, 1'b1, mk_st(0, 2'd0, 5'd1), mk_xl(0), 32'h0001_0FFF);
    chk("R9 below threshold ignores xlat", 2'd2, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_fetch();
        t_data();
        t_new_bare();
        t_old();
        t_boundary();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule